// File: doc/BRIEF.md
# CPU Bank Latch and Memory Router

This block sits beside a processor with a 16-bit address bus. During the address phase of each bus cycle, while phase 2 is low, the processor places a bank byte on its data bus. The block captures the low four bits of that byte, together with the read/write line and the two valid-address qualifiers. It holds that capture unchanged for the whole phase-2-high half of the cycle. The captured value decides which of two memories serves the cycle. The first is the host board, reached through a bidirectional transceiver on the socket data pins. The second is a local 512KB SRAM made of eight 64KB regions.

A bank of zero goes to the host board. Any nonzero bank goes to the local SRAM, and only its three low bits select the SRAM region. As a result, banks 9 to 15 land on the same storage as banks 1 to 7, and bank 8 lands on region zero. During phase-2 high the block drives the SRAM chip-select, output-enable and write-enable strobes, the transceiver enable and the transceiver direction. It also drives a 19-bit SRAM address made of the region bits above the CPU address.

All logic is synchronous to a fast system clock. The phase-2 signal is sampled as a level on that clock. The strobe outputs follow the live phase-2 level, so they fall back to inactive as soon as phase 2 drops.

Top module: `cpu_bank_router`

## Requirements
- R1: After reset, with phase 2 low, all SRAM strobes are high (inactive), the transceiver enable is high (disabled) and the SRAM region bits are 000.
- R2: The bank bits, read/write and both qualifiers are sampled on every system clock while phase 2 is low. They hold while phase 2 is high, so data-bus changes in that half alter no output.
- R3: The SRAM address is the three region bits (bits 18..16) above the 16-bit CPU address (bits 15..0).
- R4: With latched bank bits 3..0 equal to 0000 and a valid address, phase-2 high enables the transceiver (en_n = 0) and keeps the SRAM chip select high.
- R5: With any latched bank bit at one and a valid address, phase-2 high pulls the SRAM chip select low and keeps the transceiver disabled.
- R6: The SRAM region bits equal latched bank bits 2..0. Banks 9..15 give the same region bits as banks 1..7 and still select the SRAM. Bank 8 selects the SRAM with region bits 000.
- R7: On an enabled host cycle, the transceiver direction output is 1 (toward the CPU) when read/write is 1 (read) and 0 (toward the socket) when it is 0 (write).
- R8: Output enable goes low only on a local read and write enable goes low only on a local write; the two are never low together.
- R9: While phase 2 is low, chip select, output enable, write enable and the transceiver enable are all high.
- R10: A cycle latched with both the program-address and data-address qualifiers at 0 selects neither memory: chip select and transceiver enable both stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phase 2 |
| rst | input | 1 | Synchronous active-high reset |
| cpu_phi2 | input | 1 | CPU phase-2 clock level |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_vpa | input | 1 | Valid program address qualifier |
| cpu_vda | input | 1 | Valid data address qualifier |
| cpu_addr | input | 16 | CPU address bus |
| cpu_db_in | input | 8 | CPU data bus as seen by the block |
| sram_addr | output | 19 | Local SRAM address, region bits on top |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| xcvr_en_n | output | 1 | Socket transceiver enable, active low |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward CPU |

## Verification
The bench targets the aliasing corner first: every bank from 8 to 15 is checked against its low-three-bit twin. A design that routed on only three bits would send bank 8 to the host board. A design that routed on the full nibble for addressing would produce region bits the SRAM does not have.

A second case toggles the data bus to all ones during phase-2 high. A latch that stayed transparent there would change the region bits mid-cycle. A bank-zero cycle with no valid qualifier must reach neither memory; a design that ignored the qualifiers would enable the transceiver on idle cycles.

Read and write host cycles confirm the transceiver direction. Local cycles confirm that output enable and write enable never overlap.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;

    localparam int CPU_ADDR_W = 16;
    localparam int DBUS_W     = 8;
    localparam int BANK_W     = 4;
    localparam int REGION_W   = 3;
    localparam int SRAM_ADDR_W = CPU_ADDR_W + REGION_W;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_HOST  = 2'd1,
        TGT_LOCAL = 2'd2
    } target_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              rd;
        logic              prog_ok;
        logic              data_ok;
    } cyc_info_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } sram_ctl_t;

    typedef struct packed {
        logic en_n;
        logic to_cpu;
    } xcvr_ctl_t;

    localparam cyc_info_t CYC_IDLE = '{bank: '0, rd: 1'b1, prog_ok: 1'b0, data_ok: 1'b0};
    localparam sram_ctl_t SRAM_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
    localparam xcvr_ctl_t XCVR_OFF = '{en_n: 1'b1, to_cpu: 1'b1};

    function automatic logic addr_qualified(cyc_info_t c);
        return c.prog_ok | c.data_ok;
    endfunction

    function automatic target_e pick_target(cyc_info_t c);
        if (!addr_qualified(c))
            return TGT_NONE;
        else if (|c.bank)
            return TGT_LOCAL;
        else
            return TGT_HOST;
    endfunction

endpackage

// File: rtl/bank_latch.sv
module bank_latch
    import bank_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              rw,
    input  logic              vpa,
    input  logic              vda,
    input  logic [DBUS_W-1:0] dbus,
    output cyc_info_t         info
);

    cyc_info_t nxt;

    always_comb begin
        nxt.bank    = dbus[BANK_W-1:0];
        nxt.rd      = rw;
        nxt.prog_ok = vpa;
        nxt.data_ok = vda;
    end

    // transparent-on-low capture: the last sample before phase 2 rises is held
    always_ff @(posedge clk) begin
        if (rst)
            info <= CYC_IDLE;
        else if (!phi2)
            info <= nxt;
    end

endmodule

// File: rtl/route_decode.sv
module route_decode
    import bank_router_pkg::*;
(
    input  cyc_info_t           info,
    output target_e             tgt,
    output logic [REGION_W-1:0] region
);

    // region bits come straight from the low bank bits; the top bank bit
    // takes part only in routing
    for (genvar i = 0; i < REGION_W; i++) begin : g_region
        assign region[i] = info.bank[i];
    end

    assign tgt = pick_target(info);

endmodule

// File: rtl/sram_strobes.sv
module sram_strobes
    import bank_router_pkg::*;
(
    input  logic      phi2,
    input  target_e   tgt,
    input  logic      rd,
    output sram_ctl_t ctl
);

    always_comb begin
        ctl = SRAM_OFF;
        if (phi2 && tgt == TGT_LOCAL) begin
            ctl.ce_n = 1'b0;
            ctl.oe_n = !rd;
            ctl.we_n = rd;
        end
    end

endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
    import bank_router_pkg::*;
(
    input  logic      phi2,
    input  target_e   tgt,
    input  logic      rd,
    output xcvr_ctl_t ctl
);

    always_comb begin
        ctl = XCVR_OFF;
        ctl.to_cpu = rd;
        if (phi2 && tgt == TGT_HOST)
            ctl.en_n = 1'b0;
    end

endmodule

// File: rtl/cpu_bank_router.sv
module cpu_bank_router
    import bank_router_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_phi2,
    input  logic                   cpu_rw,
    input  logic                   cpu_vpa,
    input  logic                   cpu_vda,
    input  logic [CPU_ADDR_W-1:0]  cpu_addr,
    input  logic [DBUS_W-1:0]      cpu_db_in,
    output logic [SRAM_ADDR_W-1:0] sram_addr,
    output logic                   sram_ce_n,
    output logic                   sram_oe_n,
    output logic                   sram_we_n,
    output logic                   xcvr_en_n,
    output logic                   xcvr_to_cpu
);

    cyc_info_t           info;
    target_e             tgt;
    logic [REGION_W-1:0] region;
    sram_ctl_t           sctl;
    xcvr_ctl_t           xctl;

    bank_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .phi2 (cpu_phi2),
        .rw   (cpu_rw),
        .vpa  (cpu_vpa),
        .vda  (cpu_vda),
        .dbus (cpu_db_in),
        .info (info)
    );

    route_decode u_route (
        .info   (info),
        .tgt    (tgt),
        .region (region)
    );

    sram_strobes u_sram (
        .phi2 (cpu_phi2),
        .tgt  (tgt),
        .rd   (info.rd),
        .ctl  (sctl)
    );

    xcvr_ctrl u_xcvr (
        .phi2 (cpu_phi2),
        .tgt  (tgt),
        .rd   (info.rd),
        .ctl  (xctl)
    );

    assign sram_addr   = {region, cpu_addr};
    assign sram_ce_n   = sctl.ce_n;
    assign sram_oe_n   = sctl.oe_n;
    assign sram_we_n   = sctl.we_n;
    assign xcvr_en_n   = xctl.en_n;
    assign xcvr_to_cpu = xctl.to_cpu;

endmodule

// File: rtl/cpu_bank_router_chk.sv
module cpu_bank_router_chk
    import bank_router_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   cpu_phi2,
    input logic                   cpu_vpa,
    input logic                   cpu_vda,
    input logic [DBUS_W-1:0]      cpu_db_in,
    input logic [SRAM_ADDR_W-1:0] sram_addr,
    input logic                   sram_ce_n,
    input logic                   sram_oe_n,
    input logic                   sram_we_n,
    input logic                   xcvr_en_n
);

    localparam int HI = SRAM_ADDR_W - 1;
    localparam int LO = CPU_ADDR_W;

    assert_region_hold_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_phi2 && $past(cpu_phi2) |-> $stable(sram_addr[HI:LO]));

    assert_host_route_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_phi2) && $past(cpu_db_in[BANK_W-1:0]) == '0 && $past(cpu_vpa || cpu_vda)
        |-> sram_ce_n && !xcvr_en_n);

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(!sram_ce_n && !xcvr_en_n));

    assert_region_bits_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_phi2) |-> sram_addr[HI:LO] == $past(cpu_db_in[REGION_W-1:0]));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(!sram_oe_n && !sram_we_n) && (sram_oe_n || !sram_ce_n));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        !cpu_phi2 |-> sram_ce_n && sram_oe_n && sram_we_n && xcvr_en_n);

    assert_no_qual_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_phi2) && !$past(cpu_vpa) && !$past(cpu_vda) |-> sram_ce_n && xcvr_en_n);

endmodule

bind cpu_bank_router cpu_bank_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_phi2  (cpu_phi2),
    .cpu_vpa   (cpu_vpa),
    .cpu_vda   (cpu_vda),
    .cpu_db_in (cpu_db_in),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .xcvr_en_n (xcvr_en_n)
);

// File: tb/cpu_bank_router_tb.sv
module cpu_bank_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_phi2 = 1'b0;
    logic        cpu_rw = 1'b1;
    logic        cpu_vpa = 1'b0;
    logic        cpu_vda = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_db_in = '0;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, xcvr_en_n, xcvr_to_cpu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_bank_router u_dut (
        .clk(clk), .rst(rst), .cpu_phi2(cpu_phi2), .cpu_rw(cpu_rw),
        .cpu_vpa(cpu_vpa), .cpu_vda(cpu_vda), .cpu_addr(cpu_addr),
        .cpu_db_in(cpu_db_in), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .xcvr_en_n(xcvr_en_n),
        .xcvr_to_cpu(xcvr_to_cpu)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // address phase with the bank byte, then phase 2 high with data on the bus
    task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] addr,
                             input logic rw, input logic vpa, input logic vda,
                             input logic [7:0] hi_data);
        @(negedge clk);
        cpu_phi2 = 1'b0; cpu_db_in = bank; cpu_addr = addr;
        cpu_rw = rw; cpu_vpa = vpa; cpu_vda = vda;
        repeat (3) @(negedge clk);
        cpu_phi2 = 1'b1; cpu_db_in = hi_data;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_cycle();
        cpu_phi2 = 1'b0; cpu_vpa = 1'b0; cpu_vda = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "ce_n", sram_ce_n, 1);
        chk("R1", "oe_n", sram_oe_n, 1);
        chk("R1", "we_n", sram_we_n, 1);
        chk("R1", "en_n", xcvr_en_n, 1);
        chk("R1", "region", sram_addr[18:16], 0);
    endtask

    task automatic t_host(input logic rw);
        bus_cycle(8'h00, 16'h1234, rw, 1'b0, 1'b1, 8'h5A);
        chk("R4", "host en_n", xcvr_en_n, 0);
        chk("R4", "host ce_n", sram_ce_n, 1);
        chk("R7", "dir", xcvr_to_cpu, rw);
        chk("R8", "host oe_n", sram_oe_n, 1);
        chk("R8", "host we_n", sram_we_n, 1);
        end_cycle();
        chk("R9", "low ce_n", sram_ce_n, 1);
        chk("R9", "low en_n", xcvr_en_n, 1);
    endtask

    task automatic t_local(input logic [7:0] bank, input logic [15:0] addr, input logic rw);
        bus_cycle(bank, addr, rw, 1'b1, 1'b0, 8'h00);
        chk("R5", "local ce_n", sram_ce_n, 0);
        chk("R5", "local en_n", xcvr_en_n, 1);
        chk("R8", "local oe_n", sram_oe_n, rw ? 0 : 1);
        chk("R8", "local we_n", sram_we_n, rw ? 1 : 0);
        chk("R3", "sram_addr", sram_addr, {bank[2:0], addr});
        end_cycle();
        chk("R9", "low oe_n", sram_oe_n, 1);
        chk("R9", "low we_n", sram_we_n, 1);
    endtask

    task automatic t_alias();
        for (int b = 8; b < 16; b++) begin
            bus_cycle(8'(b), 16'hBEEF, 1'b1, 1'b1, 1'b1, 8'h00);
            chk("R6", "alias region", sram_addr[18:16], b - 8);
            chk("R6", "alias ce_n", sram_ce_n, 0);
            chk("R6", "alias en_n", xcvr_en_n, 1);
            end_cycle();
        end
    endtask

    task automatic t_hold();
        bus_cycle(8'h02, 16'h0F0F, 1'b1, 1'b0, 1'b1, 8'hFF);
        chk("R2", "region hold", sram_addr[18:16], 2);
        @(negedge clk); cpu_db_in = 8'h00; cpu_rw = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "region after bus change", sram_addr[18:16], 2);
        chk("R2", "oe_n held", sram_oe_n, 0);
        chk("R2", "ce_n held", sram_ce_n, 0);
        end_cycle();
    endtask

    task automatic t_noqual();
        bus_cycle(8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R10", "none en_n", xcvr_en_n, 1);
        chk("R10", "none ce_n", sram_ce_n, 1);
        end_cycle();
        bus_cycle(8'h05, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R10", "none local ce_n", sram_ce_n, 1);
        chk("R10", "none local we_n", sram_we_n, 1);
        end_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host(1'b1);
        t_host(1'b0);
        t_local(8'h03, 16'hA55A, 1'b1);
        t_local(8'h05, 16'h0001, 1'b0);
        t_local(8'h87, 16'hFFFF, 1'b1);
        t_alias();
        t_hold();
        t_noqual();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule